// File: doc/BRIEF.md
# One-Time-Programmable Word Array Controller

This block gives software register access to a one-time-programmable array of 32-bit words. Software writes an access descriptor, then a start register, and a sequencer carries out the operation against the array without further help. A read fetches a run of consecutive words into a bank of result registers. A program sets chosen bits in a single word, then reads the word back to confirm it.

Fuses can only move from 0 to 1. A program therefore merges the requested bits into the stored word. Bits that are already set stay set. If the read-back value is not the merged value, a dedicated failure flag is raised in place of the done flag.

Outcomes are reported as separate sticky flags in a status register that is cleared by writing ones. The array is modelled inside the block as a storage bank with a fixed, parameterised access latency. The register bus is a single-cycle write strobe with a combinational read path. The block has no streaming interface, so no valid/ready back-pressure applies.

Top module: `fuse_ctl`

## Requirements
- R1: After reset, the status register, the descriptor register, the program-data register and every result word all read 0, and the internal array holds all zeros.
- R2: A read with count N (1..8) starting at index K places array word K+i in the result slot at offset 0x20+4*i. Slots from N up to 7 read 0 afterwards. Status bit 1 (read done) is set.
- R3: A program at index K stores the old word OR the program-data register (offset 0x10). Bits already at 1 stay at 1, and the count field is ignored. Status bit 3 (program done) is set when the read-back value matches.
- R4: If the read-back after a program differs from the merged value, status bit 2 (verify failure) is set and bit 3 is not.
- R5: An operation is rejected if its code is neither 0 nor 2, or if a read count is 0 or above 8, or if the index plus the count (1 for a program) exceeds 768. A rejected operation sets only status bit 4 (error), touches no array word and leaves the result slots unchanged.
- R6: A start write that arrives while an operation is in progress has no effect. This holds even if the descriptor was changed in the meantime.
- R7: Status bits 4..1 are sticky. Writing 1 to a bit at offset 0x84 clears it, writing 0 leaves it as it is, and a flag raised in the same cycle as a clear wins.
- R8: Status bit 0 (busy) reads 1 from the cycle after an accepted start until the operation ends. Each operation raises exactly one of the bits 1, 2, 3 or 4.
- R9: The descriptor at offset 0x04 holds the word index in bits 31:16, the count in bits 11:8 and the operation code in bits 3:0, where 0 means read and 2 means program. Writing a value with bit 0 set to offset 0x08 starts the operation.
- R10: Each array access takes ACC_LAT cycles plus one issue cycle. A read of N words is busy for N*(ACC_LAT+1) cycles, and a program is busy for 3*(ACC_LAT+1) cycles. The array never receives a request while one is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |

## Verification
The bench builds the block with ACC_LAT set to 3, which keeps bursts short and makes every busy window small enough to count exactly against R10. It also sets a weak-fuse word at index 5, with mask 0x8000_0000, that refuses to blow its top bit. This is the only way a correct array can return a mismatching read-back, so it brings the verify-failure path within reach. The default build has no weak bits and an access latency of 8.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int WORD_W = 32;

  localparam logic [3:0] OP_READ = 4'd0;
  localparam logic [3:0] OP_PROG = 4'd2;

  localparam logic [7:0] A_CMD   = 8'h04;
  localparam logic [7:0] A_EN    = 8'h08;
  localparam logic [7:0] A_PDATA = 8'h10;
  localparam logic [7:0] A_DOUT  = 8'h20;
  localparam logic [7:0] A_STAT  = 8'h84;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} seq_st_t;
  typedef enum logic [1:0] {P_READ, P_OLD, P_BLOW, P_CHECK} seq_ph_t;
endpackage

// File: rtl/fuse_array.sv
module fuse_array #(
  parameter int          N_WORDS   = 768,
  parameter int          AW        = 10,
  parameter int          ACC_LAT   = 8,
  parameter int          WEAK_IDX  = 0,
  parameter logic [31:0] WEAK_MASK = 32'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic          rsp_o,
  output logic [31:0]   rdata_o
);
  localparam int CW = $clog2(ACC_LAT + 1);

  logic [31:0]   mem [N_WORDS];
  logic [CW-1:0] cnt_q;
  logic [31:0]   hold_q;
  logic          in_rng;
  logic [31:0]   weak_m;

  assign in_rng = 32'(addr_i) < N_WORDS;
  assign weak_m = (32'(addr_i) == WEAK_IDX) ? WEAK_MASK : 32'h0;

  // A request loads the latency counter. A write only merges bits (0 to 1).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
      for (int k = 0; k < N_WORDS; k++) mem[k] <= '0;
    end else if (req_i) begin
      cnt_q  <= CW'(ACC_LAT);
      hold_q <= in_rng ? mem[addr_i] : 32'h0;
      if (we_i && in_rng) mem[addr_i] <= mem[addr_i] | (wdata_i & ~weak_m);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign rsp_o   = (cnt_q == CW'(1));
  assign rdata_o = hold_q;

  // R10: a new request only when nothing is pending
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |-> (cnt_q == '0));

  // R3: a programmed word never loses a set bit
  a_r3_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && we_i && in_rng) |=>
      ((mem[$past(addr_i)] & $past(mem[addr_i])) == $past(mem[addr_i])));
endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
  import fuse_pkg::*;
#(
  parameter int N_WORDS   = 768,
  parameter int AW        = 10,
  parameter int MAX_BURST = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start_i,
  input  logic [31:0]                     cmd_i,
  input  logic [31:0]                     pdata_i,
  input  logic                            arr_rsp_i,
  input  logic [31:0]                     arr_rdata_i,
  output logic                            busy_o,
  output logic                            arr_req_o,
  output logic                            arr_we_o,
  output logic [AW-1:0]                   arr_addr_o,
  output logic [31:0]                     arr_wdata_o,
  output logic                            commit_o,
  output logic [MAX_BURST-1:0][31:0]      stage_o,
  output logic                            rd_done_o,
  output logic                            wr_done_o,
  output logic                            vfail_o,
  output logic                            err_o
);
  localparam int IW = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1;

  seq_st_t st_q;
  seq_ph_t ph_q;
  logic [AW-1:0] idx_q;
  logic [3:0]    cnt_q;
  logic [3:0]    word_q;
  logic [31:0]   pdata_q;
  logic [31:0]   old_q;
  logic [MAX_BURST-1:0][31:0] stage_q;

  logic [15:0] f_idx;
  logic [3:0]  f_cnt;
  logic [3:0]  f_op;
  logic [16:0] f_end;
  logic        ok_rd, ok_pg;
  logic        unused_fields;

  assign f_idx = cmd_i[31:16];
  assign f_cnt = cmd_i[11:8];
  assign f_op  = cmd_i[3:0];
  assign unused_fields = ^{cmd_i[15:12], cmd_i[7:4]};

  always_comb begin
    f_end = {1'b0, f_idx} + ((f_op == OP_PROG) ? 17'd1 : 17'(f_cnt));
    ok_rd = (f_op == OP_READ) && (f_cnt != 4'd0) && (32'(f_cnt) <= MAX_BURST)
            && (32'(f_end) <= N_WORDS);
    ok_pg = (f_op == OP_PROG) && (32'(f_end) <= N_WORDS);
  end

  assign busy_o      = (st_q != S_IDLE);
  assign arr_req_o   = (st_q == S_REQ);
  assign arr_we_o    = (st_q == S_REQ) && (ph_q == P_BLOW);
  assign arr_addr_o  = idx_q + AW'(word_q);
  assign arr_wdata_o = old_q | pdata_q;
  assign stage_o     = stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  ph_q <= P_READ;
      idx_q <= '0;  cnt_q <= '0;  word_q <= '0;
      pdata_q <= '0;  old_q <= '0;  stage_q <= '0;
      commit_o <= 1'b0;  rd_done_o <= 1'b0;  wr_done_o <= 1'b0;
      vfail_o <= 1'b0;   err_o <= 1'b0;
    end else begin
      commit_o <= 1'b0;  rd_done_o <= 1'b0;  wr_done_o <= 1'b0;
      vfail_o <= 1'b0;   err_o <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          if (ok_rd) begin
            idx_q <= f_idx[AW-1:0];  cnt_q <= f_cnt;  word_q <= '0;
            ph_q <= P_READ;  stage_q <= '0;  st_q <= S_REQ;
          end else if (ok_pg) begin
            idx_q <= f_idx[AW-1:0];  cnt_q <= 4'd1;  word_q <= '0;
            pdata_q <= pdata_i;  old_q <= '0;  ph_q <= P_OLD;  st_q <= S_REQ;
          end else begin
            err_o <= 1'b1;
          end
        end
        S_REQ: st_q <= S_WAIT;
        S_WAIT: if (arr_rsp_i) begin
          case (ph_q)
            P_READ: begin
              stage_q[word_q[IW-1:0]] <= arr_rdata_i;
              if (word_q == cnt_q - 4'd1) begin
                commit_o <= 1'b1;  rd_done_o <= 1'b1;  st_q <= S_IDLE;
              end else begin
                word_q <= word_q + 4'd1;  st_q <= S_REQ;
              end
            end
            P_OLD:  begin old_q <= arr_rdata_i; ph_q <= P_BLOW;  st_q <= S_REQ; end
            P_BLOW: begin ph_q <= P_CHECK; st_q <= S_REQ; end
            default: begin
              if (arr_rdata_i == (old_q | pdata_q)) wr_done_o <= 1'b1;
              else                                  vfail_o   <= 1'b1;
              st_q <= S_IDLE;
            end
          endcase
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R8: at most one outcome per cycle
  a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rd_done_o, wr_done_o, vfail_o, err_o}) <= 1);

  // R5: a rejection never coincides with array traffic
  a_r5_err_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!arr_req_o && !busy_o));

  // R6: descriptor latches frozen while working
  a_r6_latched_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(idx_q) && $stable(pdata_q)));
endmodule

// File: rtl/fuse_ctl.sv
module fuse_ctl
  import fuse_pkg::*;
#(
  parameter int          N_WORDS   = 768,
  parameter int          MAX_BURST = 8,
  parameter int          ACC_LAT   = 8,
  parameter int          WEAK_IDX  = 0,
  parameter logic [31:0] WEAK_MASK = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  localparam int AW = $clog2(N_WORDS);

  logic [31:0] cmd_q, pdata_q;
  logic [MAX_BURST-1:0][31:0] dout_q;
  logic [3:0]  flg_q;           // {err, prog done, verify fail, read done}
  logic [3:0]  flg_set, flg_clr;

  logic start, busy, commit;
  logic rd_p, wr_p, vf_p, er_p;
  logic [MAX_BURST-1:0][31:0] stage;
  logic arr_req, arr_we, arr_rsp;
  logic [AW-1:0] arr_addr;
  logic [31:0] arr_wdata, arr_rdata;

  assign start   = bus_we && (bus_addr == A_EN) && bus_wdata[0];
  assign flg_set = {er_p, wr_p, vf_p, rd_p};
  assign flg_clr = (bus_we && bus_addr == A_STAT) ? bus_wdata[4:1] : 4'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;  pdata_q <= '0;  dout_q <= '0;  flg_q <= '0;
    end else begin
      if (bus_we && bus_addr == A_CMD)   cmd_q   <= bus_wdata;
      if (bus_we && bus_addr == A_PDATA) pdata_q <= bus_wdata;
      if (commit) dout_q <= stage;
      flg_q <= (flg_q & ~flg_clr) | flg_set;
    end
  end

  always_comb begin
    bus_rdata = 32'h0;
    case (bus_addr)
      A_CMD:   bus_rdata = cmd_q;
      A_PDATA: bus_rdata = pdata_q;
      A_STAT:  bus_rdata = {27'h0, flg_q, busy};
      default: bus_rdata = 32'h0;
    endcase
    for (int i = 0; i < MAX_BURST; i++)
      if (bus_addr == A_DOUT + 8'(4 * i)) bus_rdata = dout_q[i];
  end

  fuse_seq #(.N_WORDS(N_WORDS), .AW(AW), .MAX_BURST(MAX_BURST)) u_seq (
    .clk, .rst_n, .start_i(start), .cmd_i(cmd_q), .pdata_i(pdata_q),
    .arr_rsp_i(arr_rsp), .arr_rdata_i(arr_rdata), .busy_o(busy),
    .arr_req_o(arr_req), .arr_we_o(arr_we), .arr_addr_o(arr_addr),
    .arr_wdata_o(arr_wdata), .commit_o(commit), .stage_o(stage),
    .rd_done_o(rd_p), .wr_done_o(wr_p), .vfail_o(vf_p), .err_o(er_p));

  fuse_array #(.N_WORDS(N_WORDS), .AW(AW), .ACC_LAT(ACC_LAT),
               .WEAK_IDX(WEAK_IDX), .WEAK_MASK(WEAK_MASK)) u_arr (
    .clk, .rst_n, .req_i(arr_req), .we_i(arr_we), .addr_i(arr_addr),
    .wdata_i(arr_wdata), .rsp_o(arr_rsp), .rdata_o(arr_rdata));

  // R7: a write-one clears a flag unless it is raised in the same cycle
  a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_clr[0] && !flg_set[0]) |=> !flg_q[0]);

  // R7: a raised flag always lands
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    flg_set[3] |=> flg_q[3]);

  // R8: completion is reported only once the sequencer is idle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_p || wr_p || vf_p) |-> !busy);
endmodule

// File: tb/test_fuse_ctl.sv
`timescale 1ns/1ps
module test_fuse_ctl;
  localparam int LAT = 3;
  localparam int WIDX = 5;
  localparam logic [31:0] WMASK = 32'h8000_0000;

  typedef struct packed {
    logic [3:0]  op;
    logic [15:0] idx;
    logic [3:0]  cnt;
    logic [31:0] pdata;
    logic [4:0]  exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{4'd0, 16'd0,   4'd8, 32'h0,         5'h02},
    '{4'd2, 16'd3,   4'd0, 32'h0000_00F0, 5'h08},
    '{4'd2, 16'd3,   4'd5, 32'h0000_0F00, 5'h08},
    '{4'd0, 16'd2,   4'd3, 32'h0,         5'h02},
    '{4'd2, 16'd767, 4'd1, 32'hA5A5_0001, 5'h08},
    '{4'd0, 16'd760, 4'd8, 32'h0,         5'h02},
    '{4'd0, 16'd761, 4'd8, 32'h0,         5'h10},
    '{4'd0, 16'd4,   4'd0, 32'h0,         5'h10},
    '{4'd0, 16'd4,   4'd9, 32'h0,         5'h10},
    '{4'd1, 16'd4,   4'd1, 32'h0,         5'h10},
    '{4'd2, 16'd768, 4'd1, 32'hFFFF_FFFF, 5'h10},
    '{4'd2, 16'd5,   4'd1, 32'h8000_0001, 5'h04},
    '{4'd0, 16'd5,   4'd1, 32'h0,         5'h02},
    '{4'd2, 16'd3,   4'd1, 32'h0,         5'h08}
  };

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] model [768];

  always #2.5 clk = ~clk;

  fuse_ctl #(.ACC_LAT(LAT), .WEAK_IDX(WIDX), .WEAK_MASK(WMASK)) i_fuse_ctl (
    .clk, .rst_n, .bus_we(we), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic run_op(input logic [3:0] op, input logic [15:0] idx, input logic [3:0] cnt,
                        input logic [31:0] pd, output int cyc);
    logic [31:0] s;
    bus_wr(8'h10, pd);
    bus_wr(8'h04, {idx, 4'h0, cnt, 4'h0, op});
    bus_wr(8'h08, 32'h1);
    cyc = 0;
    for (int k = 0; k < 1000; k++) begin
      bus_rd(8'h84, s);
      if (!s[0]) break;
      cyc++;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] weak_of(input int i);
    return (i == WIDX) ? WMASK : 32'h0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] snap [8];
    int cyc;
    for (int i = 0; i < 768; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    bus_rd(8'h84, v); chk("R1 status", v, 32'h0);
    bus_rd(8'h04, v); chk("R1 cmd", v, 32'h0);
    bus_rd(8'h10, v); chk("R1 pdata", v, 32'h0);
    for (int i = 0; i < 8; i++) begin
      bus_rd(8'(8'h20 + 4 * i), v); chk("R1 dout", v, 32'h0);
    end

    // Vector walk (R2 R3 R4 R5 R8 R9 R10 R7)
    for (int n = 0; n < NV; n++) begin
      vec_t t = VT[n];
      for (int i = 0; i < 8; i++) bus_rd(8'(8'h20 + 4 * i), snap[i]);
      run_op(t.op, t.idx, t.cnt, t.pdata, cyc);
      bus_rd(8'h84, v);
      chk("R8 outcome flag", v, {27'h0, t.exp});
      if (t.exp == 5'h02) begin
        for (int i = 0; i < 8; i++) begin
          bus_rd(8'(8'h20 + 4 * i), v);
          chk("R2 read slot", v, (i < int'(t.cnt)) ? model[int'(t.idx) + i] : 32'h0);
        end
        chk("R10 read busy cycles", cyc, int'(t.cnt) * (LAT + 1));
      end else if (t.exp == 5'h10) begin
        for (int i = 0; i < 8; i++) begin
          bus_rd(8'(8'h20 + 4 * i), v); chk("R5 slots kept", v, snap[i]);
        end
        chk("R5 no busy", cyc, 0);
      end else begin
        model[t.idx] = model[t.idx] | (t.pdata & ~weak_of(int'(t.idx)));
        chk("R10 program busy cycles", cyc, 3 * (LAT + 1));
        // R3 R4: confirm array contents through a read
        run_op(4'd0, t.idx, 4'd1, 32'h0, cyc);
        bus_rd(8'h20, v); chk("R3 word after program", v, model[t.idx]);
        bus_rd(8'h84, v);
        v[1] = 1'b0;
        chk("R4 flag kept", v, {27'h0, t.exp});
        bus_wr(8'h84, 32'h2);
      end
      bus_wr(8'h84, {27'h0, t.exp});
      bus_rd(8'h84, v); chk("R7 cleared", v, 32'h0);
    end

    // R5: rejected accesses left the array alone (index 4 was never written)
    run_op(4'd0, 16'd4, 4'd1, 32'h0, cyc);
    bus_rd(8'h20, v); chk("R5 array untouched", v, 32'h0);
    bus_wr(8'h84, 32'h1E);

    // R6 R8 R9: start while busy is ignored
    bus_wr(8'h04, {16'd0, 4'h0, 4'd8, 4'h0, 4'd0});
    bus_wr(8'h08, 32'h1);
    bus_rd(8'h84, v); chk("R8 busy after start", v & 32'h1, 32'h1);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    bus_wr(8'h04, {16'd4, 4'h0, 4'd1, 4'h0, 4'd2});
    bus_wr(8'h08, 32'h1);
    repeat (60) @(negedge clk);
    bus_rd(8'h84, v); chk("R6 only read done", v, 32'h2);
    bus_wr(8'h84, 32'h2);
    run_op(4'd0, 16'd4, 4'd1, 32'h0, cyc);
    bus_rd(8'h20, v); chk("R6 word 4 unprogrammed", v, 32'h0);
    bus_wr(8'h84, 32'h2);

    // R9: enable bit 0 clear does not start
    bus_wr(8'h04, {16'd3, 4'h0, 4'd1, 4'h0, 4'd0});
    bus_wr(8'h08, 32'h2);
    repeat (20) @(negedge clk);
    bus_rd(8'h84, v); chk("R9 enable bit0 clear", v, 32'h0);

    // R7: partial clear keeps the other flag
    run_op(4'd3, 16'd0, 4'd1, 32'h0, cyc);
    run_op(4'd0, 16'd3, 4'd1, 32'h0, cyc);
    bus_rd(8'h84, v); chk("R7 two flags", v, 32'h12);
    bus_wr(8'h84, 32'h2);
    bus_rd(8'h84, v); chk("R7 partial clear", v, 32'h10);
    bus_rd(8'h20, v); chk("R2 word 3", v, model[3]);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule